// File: doc/BRIEF.md
# Thread Block Dispatcher

This block sits between the command front end of a parallel processor and its pool of streaming-multiprocessor slots. A launch request describes a grid of blocks in up to three dimensions (a dimension of size one collapses it) and how many threads every block holds. Once a launch is taken, the dispatcher walks the grid and hands out one block per cycle at most. Each block goes to a slot that is ready and still has room for that many threads. Each hand-off carries the block's coordinates, how many 32-lane warps the block fills, and which lanes of its final warp are live.

Slots report a finished block with a one-cycle pulse. That pulse frees the block's threads in that slot and counts toward the grid total. When every block of the grid has reported, a grid-done flag rises. A host fences on that flag, and it stays up until the next launch is taken. A launch that cannot run is refused with an error flag and issues nothing. Such launches are a zero thread count, more threads per block than one slot can hold, or any grid dimension of zero.

Top module: `blk_dispatch`

## Requirements
- R1: `launchReady` is high exactly when no grid is in flight. A launch is taken only on a cycle where `launchValid` and `launchReady` are both high. A `launchValid` raised while a grid is running has no effect on the blocks issued.
- R2: A taken launch with a thread count of 0, a thread count above `SM_THREAD_CAP`, or any grid dimension of 0 sets `launchErr`, clears `gridDone` and dispatches no block. `launchErr` holds until the next taken launch, and a valid taken launch clears it.
- R3: `dispWarps` equals the ceiling of the thread count divided by 32.
- R4: `dispMask` bit i is 1 for every lane i below (threads mod 32), or all 32 bits are 1 when that remainder is 0.
- R5: Blocks are issued in linear order, with X varying fastest, then Y, then Z, starting at (0,0,0).
- R6: On each cycle at most one `dispValid` bit is high. It is the lowest-numbered slot whose `dispReady` is high and whose resident thread count plus the block's thread count does not exceed `SM_THREAD_CAP`. The hand-off happens on that cycle.
- R7: Each dispatched block adds its thread count to its slot's residency, and a counted completion from that slot removes it. A slot without enough room gets no block, even when it is ready.
- R8: A `blkDone` pulse from a slot with no resident block is ignored. It neither frees capacity nor counts toward grid completion.
- R9: `gridDone` rises one cycle after the count of completed blocks reaches the grid's block count. It stays high until the next launch is taken, and it is low on the cycle after that launch.
- R10: Every block of the grid is dispatched exactly once. No `dispValid` appears after the last block of the grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Launch request present |
| launchReady | output | 1 | Dispatcher idle, launch can be taken |
| launchGridX | input | DIM_W | Grid size in X (blocks) |
| launchGridY | input | DIM_W | Grid size in Y (blocks) |
| launchGridZ | input | DIM_W | Grid size in Z (blocks) |
| launchThreads | input | THR_W | Threads per block |
| launchErr | output | 1 | Last taken launch was invalid |
| dispValid | output | SM_COUNT | One-hot block hand-off to a slot |
| dispReady | input | SM_COUNT | Slot can take a block this cycle |
| dispBlkX | output | DIM_W | X coordinate of the handed-off block |
| dispBlkY | output | DIM_W | Y coordinate of the handed-off block |
| dispBlkZ | output | DIM_W | Z coordinate of the handed-off block |
| dispWarps | output | WARP_W | Warps in the handed-off block |
| dispMask | output | LANES | Live lanes of the block's final warp |
| blkDone | input | SM_COUNT | Per-slot block-finished pulse |
| gridDone | output | 1 | All blocks of the grid have finished |

## Verification
The hardest situation to reach from the ports combines three things. The slots are full by thread count, and completions and fresh hand-offs land on the same slot in the same cycle. In that same cycle, completion pulses arrive from slots that hold nothing. The stimulus reaches this state by holding back all completions for an opening window, so every slot fills to capacity. After that window, pseudo-random ready and completion patterns are driven from a shift register. Those patterns fire completion pulses at empty slots as often as at occupied ones. A sweep of every legal thread count from 1 to 256 covers each warp count and every possible final-warp mask.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } dispState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a valid launch, clear counters
    logic issueEn;  // hand out the current block if a slot fits
  } dispCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic launchBad;  // launch inputs describe an unrunnable grid
    logic slotFound;  // some slot can take the current block
    logic lastBlock;  // current coordinates are the final block
    logic allDone;    // completions equal grid size
  } dispStat_t;

endpackage

// File: rtl/blk_dispatch_slot.sv
module blk_dispatch_slot #(
  parameter int SM_THREAD_CAP = 256,
  parameter int THR_W         = 9,
  parameter int RES_W         = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotReady,
  input  logic             grantIn,
  input  logic             doneIn,
  input  logic [THR_W-1:0] blkThreads,
  output logic             fits,
  output logic             doneOk
);

  logic [RES_W-1:0] resident;
  logic [RES_W:0]   sumWide;
  logic [RES_W-1:0] thrRes;

  assign thrRes  = RES_W'(blkThreads);
  assign sumWide = {1'b0, resident} + {1'b0, thrRes};
  assign fits    = slotReady && (sumWide <= (RES_W+1)'(SM_THREAD_CAP));
  assign doneOk  = doneIn && (resident != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resident <= '0;
    end else begin
      resident <= resident + (grantIn ? thrRes : '0) - (doneOk ? thrRes : '0);
    end
  end

endmodule

// File: rtl/blk_dispatch_dp.sv
module blk_dispatch_dp
  import blk_dispatch_pkg::*;
#(
  parameter int SM_COUNT      = 4,
  parameter int LANES         = 32,
  parameter int SM_THREAD_CAP = 256,
  parameter int DIM_W         = 4,
  parameter int THR_W         = 9,
  parameter int WARP_W        = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  dispCtrl_t           ctrl,
  output dispStat_t           stat,
  input  logic [DIM_W-1:0]    launchGridX,
  input  logic [DIM_W-1:0]    launchGridY,
  input  logic [DIM_W-1:0]    launchGridZ,
  input  logic [THR_W-1:0]    launchThreads,
  input  logic [SM_COUNT-1:0] dispReady,
  input  logic [SM_COUNT-1:0] blkDone,
  output logic [SM_COUNT-1:0] dispValid,
  output logic [DIM_W-1:0]    dispBlkX,
  output logic [DIM_W-1:0]    dispBlkY,
  output logic [DIM_W-1:0]    dispBlkZ,
  output logic [WARP_W-1:0]   dispWarps,
  output logic [LANES-1:0]    dispMask
);

  localparam int TOT_W  = 3 * DIM_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int RES_W  = $clog2(SM_THREAD_CAP + 1);

  // captured launch shape
  logic [DIM_W-1:0]  gx, gy, gz;
  logic [THR_W-1:0]  tpb;
  logic [WARP_W-1:0] warpsReg;
  logic [LANES-1:0]  maskReg;
  logic [TOT_W-1:0]  totalBlk;

  // walk state
  logic [DIM_W-1:0]  cx, cy, cz;
  logic [TOT_W-1:0]  doneCnt;

  // derived from launch inputs
  logic [THR_W:0]    thrRound;
  logic [WARP_W-1:0] warpsNew;
  logic [LANE_W-1:0] remLanes;
  logic [LANES-1:0]  maskNew;
  logic              badThr, badDim;

  // slot interface
  logic [SM_COUNT-1:0] fitsVec;
  logic [SM_COUNT-1:0] doneOkVec;
  logic [SM_COUNT-1:0] grant;
  logic                found;
  logic                advance;
  logic [TOT_W-1:0]    doneInc;

  assign thrRound = {1'b0, launchThreads} + (THR_W+1)'(LANES - 1);
  assign warpsNew = WARP_W'(thrRound / (THR_W+1)'(LANES));
  assign remLanes = LANE_W'(launchThreads % THR_W'(LANES));

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      maskNew[i] = (remLanes == '0) || (i < int'(remLanes));
    end
  end

  assign badThr = (launchThreads == '0) ||
                  ({1'b0, launchThreads} > (THR_W+1)'(SM_THREAD_CAP));
  assign badDim = (launchGridX == '0) || (launchGridY == '0) || (launchGridZ == '0);

  // per-slot residency trackers
  genvar s;
  generate
    for (s = 0; s < SM_COUNT; s++) begin : gSlot
      blk_dispatch_slot #(
        .SM_THREAD_CAP(SM_THREAD_CAP),
        .THR_W        (THR_W),
        .RES_W        (RES_W)
      ) uSlot (
        .clk       (clk),
        .rstN      (rstN),
        .slotReady (dispReady[s]),
        .grantIn   (dispValid[s]),
        .doneIn    (blkDone[s]),
        .blkThreads(tpb),
        .fits      (fitsVec[s]),
        .doneOk    (doneOkVec[s])
      );
    end
  endgenerate

  // lowest-numbered fitting slot wins
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < SM_COUNT; i++) begin
      if (!found && fitsVec[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign dispValid = ctrl.issueEn ? grant : '0;
  assign advance   = ctrl.issueEn && found;

  always_comb begin
    doneInc = '0;
    for (int i = 0; i < SM_COUNT; i++) begin
      doneInc = doneInc + TOT_W'(doneOkVec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gx       <= '0;
      gy       <= '0;
      gz       <= '0;
      tpb      <= '0;
      warpsReg <= '0;
      maskReg  <= '0;
      totalBlk <= '0;
      cx       <= '0;
      cy       <= '0;
      cz       <= '0;
      doneCnt  <= '0;
    end else if (ctrl.load) begin
      gx       <= launchGridX;
      gy       <= launchGridY;
      gz       <= launchGridZ;
      tpb      <= launchThreads;
      warpsReg <= warpsNew;
      maskReg  <= maskNew;
      totalBlk <= TOT_W'(launchGridX) * TOT_W'(launchGridY) * TOT_W'(launchGridZ);
      cx       <= '0;
      cy       <= '0;
      cz       <= '0;
      doneCnt  <= '0;
    end else begin
      doneCnt <= doneCnt + doneInc;
      if (advance) begin
        if (cx == gx - 1'b1) begin
          cx <= '0;
          if (cy == gy - 1'b1) begin
            cy <= '0;
            cz <= cz + 1'b1;
          end else begin
            cy <= cy + 1'b1;
          end
        end else begin
          cx <= cx + 1'b1;
        end
      end
    end
  end

  assign dispBlkX  = cx;
  assign dispBlkY  = cy;
  assign dispBlkZ  = cz;
  assign dispWarps = warpsReg;
  assign dispMask  = maskReg;

  assign stat.launchBad = badThr || badDim;
  assign stat.slotFound = found;
  assign stat.lastBlock = (cx == gx - 1'b1) && (cy == gy - 1'b1) && (cz == gz - 1'b1);
  assign stat.allDone   = (doneCnt == totalBlk);

endmodule

// File: rtl/blk_dispatch_ctrl.sv
module blk_dispatch_ctrl
  import blk_dispatch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      launchValid,
  input  dispStat_t stat,
  output dispCtrl_t ctrl,
  output logic      launchReady,
  output logic      launchErr,
  output logic      gridDone
);

  dispState_e state, nextState;
  logic       takeLaunch;

  assign launchReady = (state == ST_IDLE);
  assign takeLaunch  = launchReady && launchValid;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (takeLaunch && !stat.launchBad) begin
          ctrl.load = 1'b1;
          nextState = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        ctrl.issueEn = 1'b1;
        if (stat.slotFound && stat.lastBlock) nextState = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (stat.allDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      launchErr <= 1'b0;
      gridDone  <= 1'b0;
    end else begin
      state <= nextState;
      if (takeLaunch) begin
        launchErr <= stat.launchBad;
        gridDone  <= 1'b0;
      end else if (state == ST_DRAIN && stat.allDone) begin
        gridDone <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
  import blk_dispatch_pkg::*;
#(
  parameter int SM_COUNT      = 4,
  parameter int LANES         = 32,
  parameter int SM_THREAD_CAP = 256,
  parameter int DIM_W         = 4,
  parameter int THR_W         = 9,
  parameter int WARP_W        = $clog2(SM_THREAD_CAP / LANES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                launchValid,
  output logic                launchReady,
  input  logic [DIM_W-1:0]    launchGridX,
  input  logic [DIM_W-1:0]    launchGridY,
  input  logic [DIM_W-1:0]    launchGridZ,
  input  logic [THR_W-1:0]    launchThreads,
  output logic                launchErr,
  output logic [SM_COUNT-1:0] dispValid,
  input  logic [SM_COUNT-1:0] dispReady,
  output logic [DIM_W-1:0]    dispBlkX,
  output logic [DIM_W-1:0]    dispBlkY,
  output logic [DIM_W-1:0]    dispBlkZ,
  output logic [WARP_W-1:0]   dispWarps,
  output logic [LANES-1:0]    dispMask,
  input  logic [SM_COUNT-1:0] blkDone,
  output logic                gridDone
);

  dispCtrl_t ctrl;
  dispStat_t stat;

  blk_dispatch_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .launchValid(launchValid),
    .stat       (stat),
    .ctrl       (ctrl),
    .launchReady(launchReady),
    .launchErr  (launchErr),
    .gridDone   (gridDone)
  );

  blk_dispatch_dp #(
    .SM_COUNT     (SM_COUNT),
    .LANES        (LANES),
    .SM_THREAD_CAP(SM_THREAD_CAP),
    .DIM_W        (DIM_W),
    .THR_W        (THR_W),
    .WARP_W       (WARP_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .stat         (stat),
    .launchGridX  (launchGridX),
    .launchGridY  (launchGridY),
    .launchGridZ  (launchGridZ),
    .launchThreads(launchThreads),
    .dispReady    (dispReady),
    .blkDone      (blkDone),
    .dispValid    (dispValid),
    .dispBlkX     (dispBlkX),
    .dispBlkY     (dispBlkY),
    .dispBlkZ     (dispBlkZ),
    .dispWarps    (dispWarps),
    .dispMask     (dispMask)
  );

endmodule

// File: rtl/blk_dispatch_chk.sv
module blk_dispatch_chk #(
  parameter int SM_COUNT = 4,
  parameter int LANES    = 32,
  parameter int WARP_W   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                launchValid,
  input logic                launchReady,
  input logic                launchErr,
  input logic [SM_COUNT-1:0] dispValid,
  input logic [SM_COUNT-1:0] dispReady,
  input logic [WARP_W-1:0]   dispWarps,
  input logic [LANES-1:0]    dispMask,
  input logic                gridDone
);

  // R6: at most one slot is offered a block per cycle
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dispValid));

  // R6: never offer a block to a slot that is not ready
  p_ready_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid & ~dispReady) == '0);

  // R1: no hand-off while the launch side is open
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    launchReady |-> (dispValid == '0));

  // R2: a refused launch issues nothing
  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    launchErr |-> (dispValid == '0));

  // R3 R4: every handed-off block has at least one warp and one live lane
  p_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid != '0) |-> ((dispWarps != '0) && dispMask[0]));

  // R9: grid-done holds until a launch is taken
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gridDone && !(launchValid && launchReady)) |=> gridDone);

  // R9: taking a launch drops grid-done
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (launchValid && launchReady) |=> !gridDone);

  // R9: grid-done only while idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    gridDone |-> launchReady);

endmodule

bind blk_dispatch blk_dispatch_chk #(
  .SM_COUNT(SM_COUNT),
  .LANES   (LANES),
  .WARP_W  (WARP_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .launchValid(launchValid),
  .launchReady(launchReady),
  .launchErr  (launchErr),
  .dispValid  (dispValid),
  .dispReady  (dispReady),
  .dispWarps  (dispWarps),
  .dispMask   (dispMask),
  .gridDone   (gridDone)
);

// File: tb/tb_blk_dispatch.sv
`timescale 1ns/1ps
module tb_blk_dispatch;

  localparam int SM     = 4;
  localparam int LANES  = 32;
  localparam int CAP    = 256;
  localparam int DIM_W  = 4;
  localparam int THR_W  = 9;
  localparam int WARP_W = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             launchValid;
  logic             launchReady;
  logic [DIM_W-1:0] launchGridX, launchGridY, launchGridZ;
  logic [THR_W-1:0] launchThreads;
  logic             launchErr;
  logic [SM-1:0]    dispValid;
  logic [SM-1:0]    dispReady;
  logic [DIM_W-1:0] dispBlkX, dispBlkY, dispBlkZ;
  logic [WARP_W-1:0] dispWarps;
  logic [LANES-1:0] dispMask;
  logic [SM-1:0]    blkDone;
  logic             gridDone;

  int nTests = 0;
  int nFail  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  blk_dispatch dut (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchReady(launchReady),
    .launchGridX(launchGridX), .launchGridY(launchGridY), .launchGridZ(launchGridZ),
    .launchThreads(launchThreads), .launchErr(launchErr),
    .dispValid(dispValid), .dispReady(dispReady),
    .dispBlkX(dispBlkX), .dispBlkY(dispBlkY), .dispBlkZ(dispBlkZ),
    .dispWarps(dispWarps), .dispMask(dispMask),
    .blkDone(blkDone), .gridDone(gridDone)
  );

  task automatic chk(string tag, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // invalid launch: refused, nothing issued (R2)
  task automatic badLaunch(int gx, int gy, int gz, int thr);
    @(negedge clk);
    launchGridX = DIM_W'(gx); launchGridY = DIM_W'(gy); launchGridZ = DIM_W'(gz);
    launchThreads = THR_W'(thr);
    launchValid = 1'b1;
    dispReady = '1;
    #1 chk("R1 ready before bad launch", launchReady, 1);
    @(negedge clk);
    launchValid = 1'b0;
    chk("R2 err flag set", launchErr, 1);
    chk("R2 gridDone low after bad launch", gridDone, 0);
    for (int i = 0; i < 6; i++) begin
      chk("R2 no dispatch after bad launch", dispValid, 0);
      chk("R1 still ready after bad launch", launchReady, 1);
      @(negedge clk);
    end
  endtask

  // valid launch with a modelled slot pool
  task automatic runGrid(int gx, int gy, int gz, int thr, int hold);
    int res[SM];
    int resPre[SM];
    int total, issued, doneApplied, cyc, eg;
    int ex, ey, ez, expWarps;
    logic [31:0] expMask;
    logic [SM-1:0] rdy, dn;
    int rem;
    total = gx * gy * gz;
    expWarps = (thr + LANES - 1) / LANES;
    rem = thr % LANES;
    expMask = (rem == 0) ? 32'hFFFF_FFFF : ((32'h1 << rem) - 32'h1);
    for (int s = 0; s < SM; s++) res[s] = 0;
    issued = 0; doneApplied = 0; cyc = 0; ex = 0; ey = 0; ez = 0;

    @(negedge clk);
    launchGridX = DIM_W'(gx); launchGridY = DIM_W'(gy); launchGridZ = DIM_W'(gz);
    launchThreads = THR_W'(thr);
    launchValid = 1'b1;
    dispReady = '0;
    blkDone = '0;
    #1 chk("R1 ready before launch", launchReady, 1);
    @(negedge clk);
    launchValid = 1'b0;
    chk("R9 gridDone cleared by launch", gridDone, 0);
    chk("R2 err cleared by valid launch", launchErr, 0);

    while (doneApplied < total && cyc < 20000) begin
      stepLfsr();
      rdy = (cyc < hold) ? 4'hF : lfsr[3:0];
      dn  = (cyc < hold) ? 4'h0 : lfsr[7:4];
      // stray launch while busy must not disturb the grid (R1)
      if (cyc == 3) begin
        launchValid = 1'b1; launchThreads = THR_W'(7); launchGridX = DIM_W'(1);
      end else begin
        launchValid = 1'b0;
      end
      dispReady = rdy;
      blkDone = dn;
      #1;
      chk("R1 not ready while busy", launchReady, 0);
      chk("R9 gridDone low before all complete", gridDone, 0);
      eg = -1;
      if (issued < total) begin
        for (int s = 0; s < SM; s++) begin
          if (eg < 0 && rdy[s] && (res[s] + thr <= CAP)) eg = s;
        end
      end
      chk("R6 R7 R10 slot choice", dispValid, (eg < 0) ? 0 : (1 << eg));
      for (int s = 0; s < SM; s++) resPre[s] = res[s];
      if (eg >= 0) begin
        chk("R5 block x", dispBlkX, ex);
        chk("R5 block y", dispBlkY, ey);
        chk("R5 block z", dispBlkZ, ez);
        chk("R3 warp count", dispWarps, expWarps);
        chk("R4 lane mask", dispMask, expMask);
        res[eg] += thr;
        issued++;
        if (ex == gx - 1) begin
          ex = 0;
          if (ey == gy - 1) begin ey = 0; ez++; end else ey++;
        end else ex++;
      end
      for (int s = 0; s < SM; s++) begin
        if (dn[s] && resPre[s] > 0) begin  // R8: empty slots do not count
          res[s] -= thr;
          doneApplied++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    launchValid = 1'b0;
    blkDone = '0;
    chk("R10 all blocks issued", issued, total);
    chk("R9 gridDone one cycle after last completion (low)", gridDone, 0);
    @(negedge clk);
    chk("R9 gridDone raised", gridDone, 1);
    chk("R1 ready after grid", launchReady, 1);
    // stray completions from empty slots while done (R8), flag holds (R9)
    for (int i = 0; i < 3; i++) begin
      blkDone = 4'hF;
      dispReady = 4'hF;
      @(negedge clk);
      chk("R9 gridDone holds", gridDone, 1);
      chk("R10 no dispatch after grid", dispValid, 0);
    end
    blkDone = '0;
  endtask

  initial begin
    rstN = 1'b0;
    launchValid = 1'b0;
    launchGridX = '0; launchGridY = '0; launchGridZ = '0;
    launchThreads = '0;
    dispReady = '0;
    blkDone = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", launchReady, 1);
    chk("R6 reset no dispatch", dispValid, 0);
    chk("R9 reset gridDone", gridDone, 0);
    chk("R2 reset err", launchErr, 0);

    badLaunch(2, 2, 2, 0);
    badLaunch(2, 2, 2, CAP + 1);
    badLaunch(0, 3, 1, 64);
    badLaunch(3, 1, 0, 64);

    runGrid(3, 2, 2, 100, 30);  // capacity saturation, partial warp
    runGrid(5, 1, 1, 64, 0);
    runGrid(2, 3, 1, 256, 10);  // exactly one block per slot
    runGrid(1, 1, 1, 1, 0);
    runGrid(4, 4, 2, 33, 20);
    badLaunch(1, 1, 1, 300);
    runGrid(3, 3, 3, 200, 5);
    for (int t = 1; t <= CAP; t++) begin
      runGrid(1, 1, 1, t, 0);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule